// File: doc/BRIEF.md
# Same-Home Access Run Classifier

This block follows the retired instruction stream of one thread and tracks runs of consecutive memory accesses whose data lives on the same home core. For each run it keeps the home core, how deep the run has gone (saturating at a configurable threshold), the program counter of the memory instruction that opened the run, and a bit vector of every register read or written by any instruction since that point, memory or not.

When a memory access names a different home core, the current run is closed. If it reached the threshold, its opening PC and register vector are offered to a migration predictor through a one-cycle insert strobe. A run that fell short produces no strobe, and its opening instruction stays in the default remote-access class. The tracking state is then reloaded from the new access. The whole state can be read out and written back in one cycle, so it can travel with a thread that moves to another core.

Top module: `home_run_classifier`

## Requirements
- R1: After reset the state is invalid (`st_valid_o`=0, `st_depth_o`=0) and `ins_valid_o`=0. The first memory instruction seen while the state is invalid loads the state and produces no insert.
- R2: A valid memory instruction whose home equals the stored home adds one to the depth only while the depth is below the effective threshold. Otherwise the depth holds, so it saturates.
- R3: A valid memory instruction whose home differs from the stored home, seen while the state is valid and the depth is at or above the effective threshold, raises `ins_valid_o` for exactly one cycle on the edge after it. `ins_pc_o` and `ins_mask_o` then carry the stored start PC and register vector as they were before that instruction.
- R4: A run that is closed with its depth below the effective threshold produces no insert.
- R5: When a run is opened (state invalid, or a different home), the home becomes the new home, the start PC becomes the instruction PC, the depth becomes 1 and the register vector becomes that instruction's register bits only.
- R6: Every other valid instruction, memory or not, ORs its register bits (bit n = register n) into the stored vector.
- R7: A non-memory instruction never changes home, depth or start PC, whatever its home input carries.
- R8: With `in_valid_i`=0 the state does not change and no insert is made.
- R9: The threshold input is read on every instruction. A value of 0 acts as 1.
- R10: With `ld_i`=1 the state is replaced by the `ld_*` inputs on that edge, and any instruction offered in the same cycle is ignored. The `st_*` outputs always show the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_i | input | DEPTH_W | Depth threshold (0 acts as 1) |
| in_valid_i | input | 1 | A retired instruction is present |
| in_mem_i | input | 1 | The instruction accesses memory |
| in_pc_i | input | PC_W | Instruction PC |
| in_home_i | input | CORE_W | Home core of the accessed address |
| in_regs_i | input | REG_N | Registers read or written |
| ins_valid_o | output | 1 | Insert strobe |
| ins_pc_o | output | PC_W | Start PC of the closed run |
| ins_mask_o | output | REG_N | Register vector of the closed run |
| st_valid_o | output | 1 | Exported state: valid |
| st_home_o | output | CORE_W | Exported state: home core |
| st_depth_o | output | DEPTH_W | Exported state: depth |
| st_pc_o | output | PC_W | Exported state: start PC |
| st_regs_o | output | REG_N | Exported state: register vector |
| ld_i | input | 1 | Import strobe |
| ld_valid_i | input | 1 | Imported valid |
| ld_home_i | input | CORE_W | Imported home core |
| ld_depth_i | input | DEPTH_W | Imported depth |
| ld_pc_i | input | PC_W | Imported start PC |
| ld_regs_i | input | REG_N | Imported register vector |

## Verification
The assertions check on every cycle how one instruction moves the state. Non-memory and idle cycles leave the run untouched, a depth at or above the threshold stays put, an opening access reloads the four fields, and an ordinary instruction only adds register bits. An import takes over the state, and a strobe follows exactly when a qualifying run ends. Only the bench's scenarios can show that whole sequences give the right results: the depth and vector built up over several instructions, the exact PC and vector that leave with the strobe, thresholds of 0, 1 and 7, a threshold lowered mid-run, and a thread resumed from imported state.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_EXTEND = 2'd1,
      EV_OPEN   = 2'd2,
      EV_LOAD   = 2'd3
   } hrc_event_e;
endpackage

// File: rtl/hrc_event_decode.sv
module hrc_event_decode
   import hrc_pkg::*;
#(
   parameter int CORE_W = 6
) (
   input  logic              ld,
   input  logic              in_valid,
   input  logic              in_mem,
   input  logic [CORE_W-1:0] in_home,
   input  logic              st_valid,
   input  logic [CORE_W-1:0] st_home,
   output hrc_event_e        ev
);
   always_comb begin
      if (ld)
         ev = EV_LOAD;
      else if (!in_valid)
         ev = EV_NONE;
      else if (in_mem && (!st_valid || (in_home != st_home)))
         ev = EV_OPEN;
      else
         ev = EV_EXTEND;
   end
endmodule

// File: rtl/hrc_depth_ctr.sv
module hrc_depth_ctr #(
   parameter int DEPTH_W = 3
) (
   input  logic [DEPTH_W-1:0] cur,
   input  logic [DEPTH_W-1:0] thr,
   output logic               reached,
   output logic [DEPTH_W-1:0] nxt
);
   localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);
   logic [DEPTH_W-1:0] thr_eff;

   always_comb begin
      thr_eff = (thr == '0) ? ONE : thr;
      reached = (cur >= thr_eff);
      nxt     = reached ? cur : cur + ONE;
   end
endmodule

// File: rtl/hrc_mask_acc.sv
module hrc_mask_acc #(
   parameter int REG_N = 32
) (
   input  logic [REG_N-1:0] cur,
   input  logic [REG_N-1:0] add,
   input  logic             restart,
   output logic [REG_N-1:0] nxt
);
   always_comb nxt = restart ? add : (cur | add);
endmodule

// File: rtl/home_run_classifier.sv
module home_run_classifier
   import hrc_pkg::*;
#(
   parameter int CORE_W     = 6,
   parameter int DEPTH_W    = 3,
   parameter int PC_W       = 64,
   parameter int REG_N      = 32,
   parameter bit REG_INSERT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] thr_i,
   input  logic               in_valid_i,
   input  logic               in_mem_i,
   input  logic [PC_W-1:0]    in_pc_i,
   input  logic [CORE_W-1:0]  in_home_i,
   input  logic [REG_N-1:0]   in_regs_i,
   output logic               ins_valid_o,
   output logic [PC_W-1:0]    ins_pc_o,
   output logic [REG_N-1:0]   ins_mask_o,
   output logic               st_valid_o,
   output logic [CORE_W-1:0]  st_home_o,
   output logic [DEPTH_W-1:0] st_depth_o,
   output logic [PC_W-1:0]    st_pc_o,
   output logic [REG_N-1:0]   st_regs_o,
   input  logic               ld_i,
   input  logic               ld_valid_i,
   input  logic [CORE_W-1:0]  ld_home_i,
   input  logic [DEPTH_W-1:0] ld_depth_i,
   input  logic [PC_W-1:0]    ld_pc_i,
   input  logic [REG_N-1:0]   ld_regs_i
);
   localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

   if (CORE_W < 1 || CORE_W > 16) begin : g_bad_core
      $error("CORE_W out of range");
   end
   if (DEPTH_W < 1 || DEPTH_W > 8) begin : g_bad_depth
      $error("DEPTH_W out of range");
   end
   if (PC_W < 2 || REG_N < 1) begin : g_bad_widths
      $error("PC_W or REG_N out of range");
   end

   logic               valid_q;
   logic [CORE_W-1:0]  home_q;
   logic [DEPTH_W-1:0] depth_q;
   logic [PC_W-1:0]    pc_q;
   logic [REG_N-1:0]   regs_q;

   hrc_event_e         ev;
   logic               depth_reached;
   logic [DEPTH_W-1:0] depth_nxt;
   logic [REG_N-1:0]   regs_nxt;
   logic               close_hit;

   hrc_event_decode #(.CORE_W(CORE_W)) u_dec (
      .ld       (ld_i),
      .in_valid (in_valid_i),
      .in_mem   (in_mem_i),
      .in_home  (in_home_i),
      .st_valid (valid_q),
      .st_home  (home_q),
      .ev       (ev)
   );

   hrc_depth_ctr #(.DEPTH_W(DEPTH_W)) u_depth (
      .cur     (depth_q),
      .thr     (thr_i),
      .reached (depth_reached),
      .nxt     (depth_nxt)
   );

   hrc_mask_acc #(.REG_N(REG_N)) u_mask (
      .cur     (regs_q),
      .add     (in_regs_i),
      .restart (ev == EV_OPEN),
      .nxt     (regs_nxt)
   );

   // a run closes with an insert only if it was live and deep enough
   assign close_hit = (ev == EV_OPEN) && valid_q && depth_reached;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         home_q  <= '0;
         depth_q <= '0;
         pc_q    <= '0;
         regs_q  <= '0;
      end else begin
         unique case (ev)
            EV_LOAD: begin
               valid_q <= ld_valid_i;
               home_q  <= ld_home_i;
               depth_q <= ld_depth_i;
               pc_q    <= ld_pc_i;
               regs_q  <= ld_regs_i;
            end
            EV_OPEN: begin
               valid_q <= 1'b1;
               home_q  <= in_home_i;
               depth_q <= DEPTH_ONE;
               pc_q    <= in_pc_i;
               regs_q  <= regs_nxt;
            end
            EV_EXTEND: begin
               if (in_mem_i) depth_q <= depth_nxt;
               regs_q <= regs_nxt;
            end
            default: ;
         endcase
      end
   end

   generate
      if (REG_INSERT) begin : g_ins_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ins_valid_o <= 1'b0;
               ins_pc_o    <= '0;
               ins_mask_o  <= '0;
            end else begin
               ins_valid_o <= close_hit;
               if (close_hit) begin
                  ins_pc_o   <= pc_q;
                  ins_mask_o <= regs_q;
               end
            end
         end
      end else begin : g_ins_comb
         assign ins_valid_o = close_hit;
         assign ins_pc_o    = pc_q;
         assign ins_mask_o  = regs_q;
      end
   endgenerate

   assign st_valid_o = valid_q;
   assign st_home_o  = home_q;
   assign st_depth_o = depth_q;
   assign st_pc_o    = pc_q;
   assign st_regs_o  = regs_q;
endmodule

// File: rtl/hrc_checker.sv
module hrc_checker #(
   parameter int CORE_W     = 6,
   parameter int DEPTH_W    = 3,
   parameter int PC_W       = 64,
   parameter int REG_N      = 32,
   parameter bit REG_INSERT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DEPTH_W-1:0] thr_i,
   input logic               in_valid_i,
   input logic               in_mem_i,
   input logic [PC_W-1:0]    in_pc_i,
   input logic [CORE_W-1:0]  in_home_i,
   input logic [REG_N-1:0]   in_regs_i,
   input logic               ins_valid_o,
   input logic [PC_W-1:0]    ins_pc_o,
   input logic [REG_N-1:0]   ins_mask_o,
   input logic               st_valid_o,
   input logic [CORE_W-1:0]  st_home_o,
   input logic [DEPTH_W-1:0] st_depth_o,
   input logic [PC_W-1:0]    st_pc_o,
   input logic [REG_N-1:0]   st_regs_o,
   input logic               ld_i,
   input logic               ld_valid_i,
   input logic [CORE_W-1:0]  ld_home_i,
   input logic [DEPTH_W-1:0] ld_depth_i,
   input logic [PC_W-1:0]    ld_pc_i,
   input logic [REG_N-1:0]   ld_regs_i
);
   logic [DEPTH_W-1:0] thr_eff;
   logic               mem_op, opens, same_home, deep;
   assign thr_eff   = (thr_i == '0) ? DEPTH_W'(1) : thr_i;
   assign mem_op    = in_valid_i && in_mem_i && !ld_i;
   assign same_home = st_valid_o && (in_home_i == st_home_o);
   assign opens     = mem_op && !same_home;
   assign deep      = st_depth_o >= thr_eff;

   p_nonmem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !in_mem_i && !ld_i) |=>
         (st_home_o == $past(st_home_o)) && (st_depth_o == $past(st_depth_o)) &&
         (st_pc_o == $past(st_pc_o)));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid_i && !ld_i) |=>
         $stable(st_valid_o) && $stable(st_home_o) && $stable(st_depth_o) &&
         $stable(st_pc_o) && $stable(st_regs_o));

   p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op && same_home && deep) |=> $stable(st_depth_o));

   p_open_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      opens |=> st_valid_o && (st_depth_o == DEPTH_W'(1)) &&
         (st_home_o == $past(in_home_i)) && (st_pc_o == $past(in_pc_i)) &&
         (st_regs_o == $past(in_regs_i)));

   p_accumulate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !ld_i && !opens) |=>
         ((st_regs_o & $past(in_regs_i)) == $past(in_regs_i)));

   p_import_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (st_valid_o == $past(ld_valid_i)) && (st_home_o == $past(ld_home_i)) &&
         (st_depth_o == $past(ld_depth_i)) && (st_pc_o == $past(ld_pc_i)) &&
         (st_regs_o == $past(ld_regs_i)));

   generate
      if (REG_INSERT) begin : g_reg_ins
         p_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (opens && st_valid_o && deep) |=>
               ins_valid_o && (ins_pc_o == $past(st_pc_o)) &&
               (ins_mask_o == $past(st_regs_o)));
         p_no_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(opens && st_valid_o && deep) |=> !ins_valid_o);
      end
   endgenerate
endmodule

bind home_run_classifier hrc_checker #(
   .CORE_W(CORE_W), .DEPTH_W(DEPTH_W), .PC_W(PC_W), .REG_N(REG_N),
   .REG_INSERT(REG_INSERT)
) u_chk (.*);

// File: tb/tb_home_run_classifier.sv
module tb_home_run_classifier;
   localparam int CORE_W = 6, DEPTH_W = 3, PC_W = 64, REG_N = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [DEPTH_W-1:0] thr_i = 3'd2;
   logic               in_valid_i = 1'b0, in_mem_i = 1'b0;
   logic [PC_W-1:0]    in_pc_i = '0;
   logic [CORE_W-1:0]  in_home_i = '0;
   logic [REG_N-1:0]   in_regs_i = '0;
   logic               ins_valid_o;
   logic [PC_W-1:0]    ins_pc_o;
   logic [REG_N-1:0]   ins_mask_o;
   logic               st_valid_o;
   logic [CORE_W-1:0]  st_home_o;
   logic [DEPTH_W-1:0] st_depth_o;
   logic [PC_W-1:0]    st_pc_o;
   logic [REG_N-1:0]   st_regs_o;
   logic               ld_i = 1'b0, ld_valid_i = 1'b0;
   logic [CORE_W-1:0]  ld_home_i = '0;
   logic [DEPTH_W-1:0] ld_depth_i = '0;
   logic [PC_W-1:0]    ld_pc_i = '0;
   logic [REG_N-1:0]   ld_regs_i = '0;

   always #5 clk = ~clk;

   home_run_classifier dut (.*);

   int errors = 0, checks = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic instr(input logic v, input logic m, input logic [63:0] pc,
                        input logic [5:0] h, input logic [31:0] r);
      in_valid_i = v; in_mem_i = m; in_pc_i = pc; in_home_i = h; in_regs_i = r;
      @(negedge clk);
      in_valid_i = 1'b0; in_mem_i = 1'b0;
   endtask

   typedef struct packed {
      logic        vld;
      logic        mem;
      logic [15:0] pc;
      logic [5:0]  home;
      logic [31:0] regs;
      logic        eins;
      logic [15:0] epc;
      logic [31:0] emask;
      logic [5:0]  ehome;
      logic [2:0]  edepth;
      logic [31:0] eregs;
   } vec_t;

   // threshold 2 throughout the table
   localparam vec_t TBL [15] = '{
      '{1'b1,1'b1,16'h100,6'd5,32'h2,   1'b0,16'h0,  32'h0,   6'd5,3'd1,32'h2},
      '{1'b1,1'b0,16'h104,6'd5,32'hC,   1'b0,16'h0,  32'h0,   6'd5,3'd1,32'hE},
      '{1'b1,1'b1,16'h108,6'd5,32'h4,   1'b0,16'h0,  32'h0,   6'd5,3'd2,32'hE},
      '{1'b1,1'b0,16'h10C,6'd5,32'h10,  1'b0,16'h0,  32'h0,   6'd5,3'd2,32'h1E},
      '{1'b1,1'b1,16'h110,6'd9,32'h2,   1'b1,16'h100,32'h1E,  6'd9,3'd1,32'h2},
      '{1'b1,1'b1,16'h114,6'd9,32'h40,  1'b0,16'h0,  32'h0,   6'd9,3'd2,32'h42},
      '{1'b1,1'b1,16'h118,6'd9,32'h80,  1'b0,16'h0,  32'h0,   6'd9,3'd2,32'hC2},
      '{1'b1,1'b1,16'h11C,6'd9,32'h0,   1'b0,16'h0,  32'h0,   6'd9,3'd2,32'hC2},
      '{1'b1,1'b1,16'h120,6'd3,32'h1,   1'b1,16'h110,32'hC2,  6'd3,3'd1,32'h1},
      '{1'b1,1'b1,16'h124,6'd7,32'h1,   1'b0,16'h0,  32'h0,   6'd7,3'd1,32'h1},
      '{1'b1,1'b0,16'h128,6'd3,32'h100, 1'b0,16'h0,  32'h0,   6'd7,3'd1,32'h101},
      '{1'b1,1'b1,16'h12C,6'd3,32'h0,   1'b0,16'h0,  32'h0,   6'd3,3'd1,32'h0},
      '{1'b0,1'b1,16'h12E,6'd20,32'hFFFF,1'b0,16'h0, 32'h0,   6'd3,3'd1,32'h0},
      '{1'b1,1'b1,16'h130,6'd3,32'h20,  1'b0,16'h0,  32'h0,   6'd3,3'd2,32'h20},
      '{1'b1,1'b1,16'h134,6'd4,32'h8,   1'b1,16'h12C,32'h20,  6'd4,3'd1,32'h8}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset ins_valid", 64'(ins_valid_o), 64'd0);
      chk("R1 reset st_valid", 64'(st_valid_o), 64'd0);
      chk("R1 reset depth", 64'(st_depth_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R6 R7 R8
      foreach (TBL[i]) begin
         instr(TBL[i].vld, TBL[i].mem, 64'(TBL[i].pc), TBL[i].home, TBL[i].regs);
         chk($sformatf("R3/R4 vec%0d ins_valid", i), 64'(ins_valid_o), 64'(TBL[i].eins));
         if (TBL[i].eins) begin
            chk($sformatf("R3 vec%0d ins_pc", i), ins_pc_o, 64'(TBL[i].epc));
            chk($sformatf("R3 vec%0d ins_mask", i), 64'(ins_mask_o), 64'(TBL[i].emask));
         end
         chk($sformatf("R5/R7/R8 vec%0d home", i), 64'(st_home_o), 64'(TBL[i].ehome));
         chk($sformatf("R2/R5 vec%0d depth", i), 64'(st_depth_o), 64'(TBL[i].edepth));
         chk($sformatf("R6 vec%0d regs", i), 64'(st_regs_o), 64'(TBL[i].eregs));
      end
      @(negedge clk);
      chk("R3 strobe lasts one cycle", 64'(ins_valid_o), 64'd0);

      // R1: first memory op after reset makes no insert, even with threshold 1
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      thr_i = 3'd1;
      instr(1, 1, 64'h200, 6'd1, 32'h1);
      chk("R1 first mem no insert", 64'(ins_valid_o), 64'd0);
      chk("R1 first mem loads valid", 64'(st_valid_o), 64'd1);
      instr(1, 1, 64'h204, 6'd2, 32'h0);
      chk("R9 thr1 insert", 64'(ins_valid_o), 64'd1);
      chk("R9 thr1 insert pc", ins_pc_o, 64'h200);
      // R9: threshold 0 acts as 1
      thr_i = 3'd0;
      instr(1, 1, 64'h208, 6'd3, 32'h0);
      chk("R9 thr0 insert", 64'(ins_valid_o), 64'd1);
      chk("R9 thr0 insert pc", ins_pc_o, 64'h204);

      // R2: saturation at threshold 7
      thr_i = 3'd7;
      for (int k = 0; k < 8; k++) instr(1, 1, 64'h300 + 64'(k), 6'd3, 32'h0);
      chk("R2 saturate at 7", 64'(st_depth_o), 64'd7);
      thr_i = 3'd3;
      instr(1, 1, 64'h310, 6'd3, 32'h0);
      chk("R2 held above lowered thr", 64'(st_depth_o), 64'd7);
      instr(1, 1, 64'h314, 6'd4, 32'h0);
      chk("R3 insert after lowered thr", 64'(ins_valid_o), 64'd1);
      chk("R3 insert pc start", ins_pc_o, 64'h208);

      // R10: import wins over a concurrent instruction
      thr_i = 3'd2;
      ld_i = 1'b1; ld_valid_i = 1'b1; ld_home_i = 6'd10; ld_depth_i = 3'd2;
      ld_pc_i = 64'hABC; ld_regs_i = 32'h55;
      instr(1, 1, 64'h400, 6'd11, 32'h2);
      ld_i = 1'b0;
      chk("R10 import home", 64'(st_home_o), 64'd10);
      chk("R10 import depth", 64'(st_depth_o), 64'd2);
      chk("R10 import pc", st_pc_o, 64'hABC);
      chk("R10 import regs", 64'(st_regs_o), 64'h55);
      chk("R10 no insert on import", 64'(ins_valid_o), 64'd0);
      instr(1, 1, 64'h500, 6'd12, 32'h0);
      chk("R10 imported run inserts", 64'(ins_valid_o), 64'd1);
      chk("R10 imported pc", ins_pc_o, 64'hABC);
      chk("R10 imported mask", 64'(ins_mask_o), 64'h55);
      // import an invalid state: next memory op opens without insert
      ld_i = 1'b1; ld_valid_i = 1'b0; ld_depth_i = 3'd7;
      @(negedge clk);
      ld_i = 1'b0;
      chk("R10 import invalid", 64'(st_valid_o), 64'd0);
      instr(1, 1, 64'h600, 6'd12, 32'h0);
      chk("R1 invalid state no insert", 64'(ins_valid_o), 64'd0);
      chk("R5 reopen depth", 64'(st_depth_o), 64'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule